// File: doc/BRIEF.md
# Hot-swap deactivation sequencer

This controller runs the orderly power-down of a plug-in board once its ejector latch is opened. It starts in the active management state. A press of the debounced hot-swap button sends a one-cycle request strobe to the chassis manager and moves the board to the request-pending state. The manager's answer then either returns the board to the active state or moves it on to the shutdown state. Software can also command the shutdown state directly, with no request strobe.

In the shutdown state, if an ACPI-capable operating system is present, the block drives a timed active-low power-button pulse and starts a long shutdown watchdog. It then waits until the chipset reports both sleep states, seen through a two-flop synchroniser, or until the watchdog runs out, whichever comes first. Without such an OS it skips the pulse and the wait. In every case it ends by cutting payload power and setting the locked bit in the same clock edge that moves the state to the powered-off state. That state is left only through reset.

Both durations are parameters counted in clock cycles. The defaults give 3 minutes and 20 ms at 200 MHz.

Top module: `hs_deact_seq`

## Requirements
- R1: After reset, mstate_o is 4 (active), payload_pwr_o is 1, locked_o is 0, pwr_btn_no is 1 and deact_req_o is 0. The 3-bit state codes are 1 = powered off, 4 = active, 5 = request pending and 6 = shutdown.
- R2: In state 4 with hs_btn_i high and sw_force_i low, the next edge moves the state to 5 and drives deact_req_o high for exactly that one cycle. The strobe is issued again only on a later 4-to-5 move.
- R3: In state 5, cm_grant_i high moves the state to 6, and grant wins over cm_deny_i. cm_deny_i alone returns the state to 4 with payload power still on. With neither input high, the state stays at 5.
- R4: sw_force_i high in state 4 or state 5 moves the state to 6 on the next edge. It takes priority over the button and the grant, and it raises no request strobe.
- R5: If acpi_os_i is high on the edge that enters state 6, pwr_btn_no goes low for exactly PULSE_CYC cycles, starting with the first cycle that shows state 6.
- R6: If acpi_os_i is low on entry to state 6, pwr_btn_no stays high and state 6 lasts exactly one cycle before state 1.
- R7: With an OS present, both sleep_s3_i and sleep_s5_i high make the state go to 1 on the third rising edge after they rise, because they pass a two-flop synchroniser. Only one of the two inputs high has no effect.
- R8: With an OS present and the two sleep inputs not both seen, state 6 lasts exactly SHUT_CYC cycles and then goes to 1.
- R9: payload_pwr_o falls and locked_o rises in the same edge that moves the state to 1. Before that they stay at 1 and 0. State 1 holds until reset, and hs_btn_i and sw_force_i have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_btn_i | input | 1 | Debounced hot-swap button, high when the latch is open |
| cm_grant_i | input | 1 | Chassis manager grants the deactivation |
| cm_deny_i | input | 1 | Chassis manager denies the deactivation |
| acpi_os_i | input | 1 | An ACPI-capable OS is running |
| sw_force_i | input | 1 | Software command to enter state 6 |
| sleep_s3_i | input | 1 | Chipset S3 sleep indication, high when asserted (asynchronous) |
| sleep_s5_i | input | 1 | Chipset S5 sleep indication, high when asserted (asynchronous) |
| deact_req_o | output | 1 | One-cycle deactivation request strobe |
| pwr_btn_no | output | 1 | Power-button pulse, active low |
| payload_pwr_o | output | 1 | Payload power enable |
| locked_o | output | 1 | Locked bit |
| mstate_o | output | 3 | Current management state code |

## Verification
A wrong state register shows at once on mstate_o in the next sampled cycle, and it also shows on the payload and locked outputs, which must move together with the change to state 1. A wrong shutdown-timer or synchroniser count shows as a state-6 stay that is one or more cycles off the expected length: timeout length, or sleep arrival plus two. A pulse-counter fault shows as a low-pulse count other than PULSE_CYC, or as a pulse where no OS is present. A wrongly routed strobe shows as a request pulse on the forced path or a missing pulse on the button path, in the cycle the state first reads 5 or 6.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    MS_OFF    = 3'd1,
    MS_ACTIVE = 3'd4,
    MS_REQ    = 3'd5,
    MS_SHUT   = 3'd6
  } mstate_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= d_i;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hs_down_cnt.sv
module hs_down_cnt #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] LOAD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_i)    cnt_q <= LOAD;
    else if (!zero_o)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
  import hs_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    btn_i,
  input  logic    grant_i,
  input  logic    deny_i,
  input  logic    acpi_i,
  input  logic    force_i,
  input  logic    sleep_both_i,
  input  logic    tmo_i,
  output logic    enter_os_o,
  output mstate_e state_o,
  output logic    req_o,
  output logic    payload_o,
  output logic    locked_o
);
  mstate_e st_q, st_d;
  logic    wait_os_q, req_d, enter;

  always_comb begin
    st_d  = st_q;
    req_d = 1'b0;
    enter = 1'b0;
    unique case (st_q)
      MS_ACTIVE: begin
        if (force_i)    begin st_d = MS_SHUT; enter = 1'b1; end
        else if (btn_i) begin st_d = MS_REQ;  req_d = 1'b1; end
      end
      MS_REQ: begin
        if (force_i || grant_i) begin st_d = MS_SHUT; enter = 1'b1; end
        else if (deny_i)        st_d = MS_ACTIVE;
      end
      MS_SHUT: begin
        // exit on no OS, on both sleep states, or on watchdog expiry
        if (!wait_os_q || sleep_both_i || tmo_i) st_d = MS_OFF;
      end
      MS_OFF:  st_d = MS_OFF;
      default: st_d = MS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= MS_ACTIVE;
      req_o     <= 1'b0;
      wait_os_q <= 1'b0;
      payload_o <= 1'b1;
      locked_o  <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_o <= req_d;
      if (enter) wait_os_q <= acpi_i;
      if (st_d == MS_OFF) begin
        payload_o <= 1'b0;
        locked_o  <= 1'b1;
      end
    end
  end

  assign enter_os_o = enter && acpi_i;
  assign state_o    = st_q;
endmodule

// File: rtl/hs_deact_seq.sv
module hs_deact_seq
  import hs_pkg::*;
#(
  parameter longint unsigned SHUT_CYC  = 64'd36_000_000_000,
  parameter longint unsigned PULSE_CYC = 64'd4_000_000,
  parameter int unsigned     SYNC_STG  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hs_btn_i,
  input  logic       cm_grant_i,
  input  logic       cm_deny_i,
  input  logic       acpi_os_i,
  input  logic       sw_force_i,
  input  logic       sleep_s3_i,
  input  logic       sleep_s5_i,
  output logic       deact_req_o,
  output logic       pwr_btn_no,
  output logic       payload_pwr_o,
  output logic       locked_o,
  output logic [2:0] mstate_o
);
  localparam int unsigned SHUT_W  = $clog2(SHUT_CYC + 1);
  localparam int unsigned PULSE_W = $clog2(PULSE_CYC + 1);
  localparam logic [SHUT_W-1:0]  SHUT_LD  = SHUT_W'(SHUT_CYC - 1);
  localparam logic [PULSE_W-1:0] PULSE_LD = PULSE_W'(PULSE_CYC);

  logic [1:0] sleep_s;
  logic       enter_os, tmo, pulse_done;
  mstate_e    state;

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sleep_s5_i, sleep_s3_i}),
    .q_o   (sleep_s)
  );

  hs_down_cnt #(.W(SHUT_W), .LOAD(SHUT_LD)) u_shut_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(enter_os),
    .zero_o(tmo)
  );

  hs_down_cnt #(.W(PULSE_W), .LOAD(PULSE_LD)) u_pulse_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(enter_os),
    .zero_o(pulse_done)
  );

  hs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .btn_i       (hs_btn_i),
    .grant_i     (cm_grant_i),
    .deny_i      (cm_deny_i),
    .acpi_i      (acpi_os_i),
    .force_i     (sw_force_i),
    .sleep_both_i(&sleep_s),
    .tmo_i       (tmo),
    .enter_os_o  (enter_os),
    .state_o     (state),
    .req_o       (deact_req_o),
    .payload_o   (payload_pwr_o),
    .locked_o    (locked_o)
  );

  assign pwr_btn_no = pulse_done;
  assign mstate_o   = state;
endmodule

// File: rtl/hs_deact_seq_chk.sv
module hs_deact_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hs_btn_i,
  input logic       cm_grant_i,
  input logic       sw_force_i,
  input logic       deact_req_o,
  input logic       payload_pwr_o,
  input logic       locked_o,
  input logic [2:0] mstate_o
);
  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_req_o |=> !deact_req_o); // R2
  AST_REQ_ON_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_req_o |-> (mstate_o == 3'd5 && $past(mstate_o) == 3'd4 && $past(hs_btn_i))); // R2
  AST_SHUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstate_o == 3'd6 && $past(mstate_o) == 3'd5) |-> ($past(cm_grant_i) || $past(sw_force_i))); // R3
  AST_FORCE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstate_o == 3'd6 && $past(mstate_o) != 3'd6) |-> !deact_req_o); // R4
  AST_OFF_FROM_SHUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstate_o == 3'd1 && $past(mstate_o) != 3'd1) |-> $past(mstate_o) == 3'd6); // R9
  AST_OFF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstate_o == 3'd1 |=> mstate_o == 3'd1); // R9
  AST_OFF_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstate_o == 3'd1 |-> (!payload_pwr_o && locked_o)); // R9
  AST_LIVE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mstate_o != 3'd1 |-> (payload_pwr_o && !locked_o)); // R9
endmodule

bind hs_deact_seq hs_deact_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hs_btn_i     (hs_btn_i),
  .cm_grant_i   (cm_grant_i),
  .sw_force_i   (sw_force_i),
  .deact_req_o  (deact_req_o),
  .payload_pwr_o(payload_pwr_o),
  .locked_o     (locked_o),
  .mstate_o     (mstate_o)
);

// File: tb/hs_deact_seq_test.sv
`timescale 1ns/1ps
module hs_deact_seq_test;
  localparam int SHUT  = 40;
  localparam int PULS  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic btn = 0, grant = 0, deny = 0, acpi = 0, force_m6 = 0, s3 = 0, s5 = 0;
  logic req, pbtn_n, pay, lck;
  logic [2:0] st;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hs_deact_seq #(.SHUT_CYC(SHUT), .PULSE_CYC(PULS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .hs_btn_i(btn), .cm_grant_i(grant),
    .cm_deny_i(deny), .acpi_os_i(acpi), .sw_force_i(force_m6),
    .sleep_s3_i(s3), .sleep_s5_i(s5), .deact_req_o(req), .pwr_btn_no(pbtn_n),
    .payload_pwr_o(pay), .locked_o(lck), .mstate_o(st)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  function automatic int exp_shut_len(bit os, bit [1:0] mask, int d);
    if (!os) return 1;
    if (mask == 2'b11 && d + 2 < SHUT) return d + 2;
    return SHUT;
  endfunction

  function automatic int exp_low(bit os);
    return os ? PULS : 0;
  endfunction

  task automatic do_reset();
    btn = 0; grant = 0; deny = 0; force_m6 = 0; s3 = 0; s5 = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(st == 3'd4 && pay && !lck && pbtn_n && !req, "R1 reset", st, 4);
  endtask

  task automatic goto_req();
    btn = 1;
    @(negedge clk);
    btn = 0;
    chk(st == 3'd5, "R2 state", st, 5);
    chk(req == 1'b1, "R2 strobe high", req, 1);
    @(negedge clk);
    chk(req == 1'b0, "R2 strobe single", req, 0);
  endtask

  // via: 0 button+grant, 1 force from active, 2 button then force; ends at first state-6 sample
  task automatic enter_shut(int via);
    if (via == 1) begin
      force_m6 = 1; btn = 1;
      @(negedge clk);
      force_m6 = 0; btn = 0;
      chk(st == 3'd6 && !req, "R4 force from active", st, 6);
    end else begin
      goto_req();
      if (via == 2) force_m6 = 1; else grant = 1;
      @(negedge clk);
      force_m6 = 0; grant = 0;
      chk(st == 3'd6, (via == 2) ? "R4 force from pending" : "R3 grant", st, 6);
      chk(!req, "R4 no strobe on shutdown entry", req, 0);
    end
  endtask

  task automatic scenario(int via, bit os, bit [1:0] mask, int d);
    int n = 0, low = 0;
    bit done = 0;
    do_reset();
    acpi = os;
    enter_shut(via);
    acpi = 0;
    for (int t = 1; t <= SHUT + 8 && !done; t++) begin
      if (st == 3'd6) begin
        n++;
        chk(pay && !lck, "R9 power held in shutdown", pay, 1);
      end else done = 1;
      if (!pbtn_n) low++;
      if (t == d) begin s3 = mask[0]; s5 = mask[1]; end
      if (!done) @(negedge clk);
    end
    chk(st == 3'd1, "R9 off state", st, 1);
    chk(n == exp_shut_len(os, mask, d),
        !os ? "R6 no-OS length" : (mask == 2'b11 ? "R7 sleep exit" : "R8 timeout"),
        n, exp_shut_len(os, mask, d));
    chk(!pay && lck, "R9 off outputs", {pay, lck}, 1);
    repeat (PULS + 2) begin
      @(negedge clk);
      if (!pbtn_n) low++;
    end
    chk(low == exp_low(os), os ? "R5 pulse width" : "R6 no pulse", low, exp_low(os));
    btn = 1; force_m6 = 1;
    repeat (2) @(negedge clk);
    btn = 0; force_m6 = 0;
    @(negedge clk);
    chk(st == 3'd1 && !pay && lck, "R9 off ignores inputs", st, 1);
    s3 = 0; s5 = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R3 hold, deny, then grant beats deny
    do_reset();
    goto_req();
    repeat (4) @(negedge clk);
    chk(st == 3'd5 && !req, "R3 hold in pending", st, 5);
    deny = 1;
    @(negedge clk);
    deny = 0;
    chk(st == 3'd4 && pay && !lck, "R3 deny returns", st, 4);
    goto_req();
    grant = 1; deny = 1;
    @(negedge clk);
    grant = 0; deny = 0;
    chk(st == 3'd6, "R3 grant wins", st, 6);
    // R7 single sleep input only: timeout path
    scenario(0, 1, 2'b01, 2);
    scenario(0, 1, 2'b10, 3);
    scenario(0, 1, 2'b11, 1);
    scenario(1, 1, 2'b11, SHUT - 2);
    scenario(2, 0, 2'b11, 1);
    scenario(0, 1, 2'b00, 0);
    for (int i = 0; i < 14; i++) begin
      int via = int'($urandom_range(2, 0));
      bit os = 1'($urandom_range(1, 0));
      bit [1:0] m = 2'($urandom_range(3, 0));
      int d = int'($urandom_range(SHUT + 4, 1));
      scenario(via, os, m, d);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule